// File: doc/BRIEF.md
# I2C Register Target

This block lets an I2C host read and write a small bank of 8-bit registers. It watches SCL and SDA, which arrive already synchronised to the system clock. It finds START, repeated START and STOP conditions and compares the first byte of each transfer with its own 7-bit address. It keeps a register pointer that is set by the first byte after the address. The pointer then steps forward after every data byte moved in either direction. The block never drives SDA high. It pulls the line low through an open-drain enable, both to acknowledge and to send zero bits of read data.

The register bank sits on a plain parallel port: pointer, write data, a one-cycle write strobe, combinational read data, and a flag that marks the pointed-to register as supported. The bank has no valid/ready handshake because the bus sets the pace, not the bank. Read data and the supported flag must be valid in the same cycle the pointer is presented, and the bank must take a strobed write in that cycle. The 6 upper address bits are a parameter. The lowest address bit comes from a select pin, so two instances can share one bus.

Top module: `i2c_reg_target`

## Requirements
- R1: An SDA fall while SCL stays high is a START. An SDA rise while SCL stays high is a STOP. A START in any state restarts address reception. A STOP in any state releases SDA and returns the block to idle.
- R2: The first byte after a START is received MSB first. Bits [7:1] are compared with {DEV_ADDR_HI, a0} and bit 0 is R/W (0 = host writes, 1 = host reads). On a match the block holds SDA low for the whole ninth clock.
- R3: a0 is taken from addr_sel during reset and again whenever an address byte of 0x00 arrives. The 0x00 byte itself is not acknowledged. A change on addr_sel at any other time has no effect on the address.
- R4: In a write, the byte after the address loads the pointer and is always acknowledged. Each later byte targets the current pointer, and the pointer then increments, wrapping from 0xFF to 0x00.
- R5: A write of a data byte raises reg_we for exactly one cycle. The strobe comes after the eighth data bit is sampled and before the acknowledge is driven. While reg_we is high, reg_wdata holds the byte and reg_addr holds the pointer.
- R6: A data byte is acknowledged and strobed only if reg_supported is high for the pointer. Otherwise SDA stays released (NACK) and no strobe occurs.
- R7: After an address byte with R/W=1 is acknowledged, the block shifts out reg_rdata at the pointer, MSB first. A host acknowledge fetches the next byte from the incremented pointer.
- R8: A host NACK after a read byte ends the transfer. The block keeps SDA released through any further clocks until a START or STOP.
- R9: After an address that does not match, the block sends a NACK and keeps SDA released for the rest of the transfer.
- R10: The pointer resets to 0x00 and keeps its value across STOP. A read that starts without a pointer byte continues from where the last transfer left it.
- R11: sda_oe changes only in the cycle after a falling SCL edge, while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| sda_oe | output | 1 | High pulls SDA low |
| addr_sel | input | 1 | Source of the lowest address bit |
| reg_addr | output | PTR_W | Register pointer |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Byte stored at reg_addr |
| reg_supported | input | 1 | reg_addr selects a supported register |

## Verification
Every cycle, the assertions check these properties:
- sda_oe only rises or falls while SCL is low.
- reg_we is a single-cycle pulse that only lands on a supported register.
- reg_we comes while SDA is still released, and the pointer holds through it.
- A STOP always leaves SDA released.

Only the bench's transfers can show the rest:
- which bytes are acknowledged;
- what data reaches which register;
- how the pointer moves across bursts, across the 0xFF wrap and across STOP;
- how the address bit is reloaded by a general call;
- that aborted, foreign and NACK-terminated transfers leave the bank untouched.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W    = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign bus_start = scl_i & scl_q & sda_q & ~sda_i;
  assign bus_stop  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_ptr_reg.sv
module i2c_ptr_reg #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr + PTR_W'(1);
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR_HI = 6'h16,
  parameter int         PTR_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              addr_sel,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata,
  input  logic              reg_supported
);
  localparam int LAST_BIT = BYTE_W - 1;

  logic scl_rise, scl_fall, bus_start, bus_stop;

  tgt_state_e             state, ack_next;
  logic [BIT_CNT_W-1:0]   bit_cnt;
  logic [BYTE_W-1:0]      shreg, rx_byte, wdata_q;
  logic                   in_ack, ack_bit, inc_after_ack;
  logic                   a0, sda_oe_q, we_q;
  logic                   last_bit, ptr_load, ptr_inc;
  logic [PTR_W-1:0]       ptr;

  i2c_bus_monitor u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  assign rx_byte  = {shreg[BYTE_W-2:0], sda_i};
  assign last_bit = (bit_cnt == BIT_CNT_W'(LAST_BIT));

  // pointer byte loads, finished data bytes step the pointer
  assign ptr_load = (state == ST_PTR) && scl_rise && last_bit;
  assign ptr_inc  = ((state == ST_ACK) && scl_fall && in_ack && inc_after_ack) ||
                    ((state == ST_RDATA) && scl_fall && last_bit);

  i2c_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (rx_byte[PTR_W-1:0]),
    .inc      (ptr_inc),
    .ptr      (ptr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      ack_next      <= ST_IDLE;
      bit_cnt       <= '0;
      shreg         <= '0;
      wdata_q       <= '0;
      in_ack        <= 1'b0;
      ack_bit       <= 1'b0;
      inc_after_ack <= 1'b0;
      a0            <= addr_sel;
      sda_oe_q      <= 1'b0;
      we_q          <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (bus_stop) begin
        state    <= ST_IDLE;
        sda_oe_q <= 1'b0;
        in_ack   <= 1'b0;
      end else if (bus_start) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        sda_oe_q <= 1'b0;
        in_ack   <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (scl_rise) begin
              shreg   <= rx_byte;
              bit_cnt <= bit_cnt + BIT_CNT_W'(1);
              if (last_bit) begin
                ack_bit       <= 1'b1;
                inc_after_ack <= 1'b0;
                ack_next      <= ST_WDATA;
                state         <= ST_ACK;
                if (state == ST_ADDR) begin
                  if (rx_byte == '0) begin
                    a0    <= addr_sel;
                    state <= ST_IDLE;
                  end else if (rx_byte[BYTE_W-1:1] == {DEV_ADDR_HI, a0}) begin
                    ack_next <= rx_byte[0] ? ST_RDATA : ST_PTR;
                  end else begin
                    state <= ST_IDLE;
                  end
                end else if (state == ST_WDATA) begin
                  ack_bit       <= reg_supported;
                  we_q          <= reg_supported;
                  wdata_q       <= rx_byte;
                  inc_after_ack <= 1'b1;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (!in_ack) begin
                sda_oe_q <= ack_bit;
                in_ack   <= 1'b1;
              end else begin
                in_ack  <= 1'b0;
                bit_cnt <= '0;
                if (ack_next == ST_RDATA) begin
                  shreg    <= {reg_rdata[BYTE_W-2:0], 1'b0};
                  sda_oe_q <= ~reg_rdata[BYTE_W-1];
                end else begin
                  sda_oe_q <= 1'b0;
                end
                state <= ack_next;
              end
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (last_bit) begin
                sda_oe_q <= 1'b0;
                in_ack   <= 1'b0;
                state    <= ST_RACK;
              end else begin
                sda_oe_q <= ~shreg[BYTE_W-1];
                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                bit_cnt  <= bit_cnt + BIT_CNT_W'(1);
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              if (sda_i) state  <= ST_IDLE;
              else       in_ack <= 1'b1;
            end else if (scl_fall && in_ack) begin
              in_ack   <= 1'b0;
              bit_cnt  <= '0;
              shreg    <= {reg_rdata[BYTE_W-2:0], 1'b0};
              sda_oe_q <= ~reg_rdata[BYTE_W-1];
              state    <= ST_RDATA;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe    = sda_oe_q;
  assign reg_we    = we_q;
  assign reg_wdata = wdata_q;
  assign reg_addr  = ptr;
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_i,
  input logic             sda_oe,
  input logic             reg_we,
  input logic             reg_supported,
  input logic [PTR_W-1:0] reg_addr
);
  a_r11_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  a_r11_oe_fall_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_i);

  a_r5_we_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  a_r5_we_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !sda_oe);

  a_r5_ptr_holds_on_we: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> $stable(reg_addr));

  a_r6_we_supported_only: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> reg_supported);

  a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_i) && scl_i && !$past(sda_i) && sda_i) |=> !sda_oe);
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.PTR_W(PTR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .scl_i         (scl_i),
  .sda_i         (sda_i),
  .sda_oe        (sda_oe),
  .reg_we        (reg_we),
  .reg_supported (reg_supported),
  .reg_addr      (reg_addr)
);

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
  localparam int QT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_drv = 1'b1, sda_drv = 1'b1;
  logic       addr_sel = 1'b0;
  logic       sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_supported;
  wire        sda_line = sda_drv & ~sda_oe;

  logic [7:0] mem [256];
  logic [7:0] em  [256];
  int errors = 0, checks = 0, we_cnt = 0, bad_oe = 0;
  logic [7:0] exp_ptr = 8'h00;
  logic [6:0] dev7 = 7'h2C;
  logic oe_seen = 1'b0, scl_seen = 1'b1;
  bit done = 1'b0;

  always #5 clk = ~clk;

  function automatic bit sup(input logic [7:0] a);
    return (a < 8'h20) || (a == 8'hFF);
  endfunction

  assign reg_supported = sup(reg_addr);
  assign reg_rdata     = mem[reg_addr];

  i2c_reg_target i_i2c_reg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .reg_supported(reg_supported)
  );

  always @(posedge clk) begin
    if (reg_we) begin
      we_cnt <= we_cnt + 1;
      if (sup(reg_addr)) mem[reg_addr] <= reg_wdata;
    end
    if (rst_n && (sda_oe != oe_seen) && scl_seen) bad_oe <= bad_oe + 1;
    oe_seen  <= sda_oe;
    scl_seen <= scl_drv;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hwait();
    repeat (QT) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_drv = 1'b1; hwait(); scl_drv = 1'b1; hwait();
    sda_drv = 1'b0; hwait(); scl_drv = 1'b0; hwait();
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; hwait(); scl_drv = 1'b1; hwait(); sda_drv = 1'b1; hwait();
  endtask

  task automatic put_bit(input logic b);
    sda_drv = b; hwait(); scl_drv = 1'b1; hwait(); hwait(); scl_drv = 1'b0; hwait();
  endtask

  task automatic get_bit(output logic b);
    sda_drv = 1'b1; hwait(); scl_drv = 1'b1; hwait(); b = sda_line; hwait();
    scl_drv = 1'b0; hwait();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~ack);
  endtask

  // write n bytes from the data list starting at ptr; checks every acknowledge
  task automatic wr_txn(input logic [7:0] ptr, input int n, input logic [7:0] data [8]);
    logic ack;
    logic [7:0] p;
    i2c_start();
    send_byte({dev7, 1'b0}, ack);
    check(ack, "R2 write address ack", ack, 1);
    send_byte(ptr, ack);
    check(ack, "R4 pointer byte ack", ack, 1);
    p = ptr;
    for (int k = 0; k < n; k++) begin
      send_byte(data[k], ack);
      check(ack == sup(p), "R6 data ack", ack, sup(p));
      if (sup(p)) em[p] = data[k];
      p = p + 8'd1;
    end
    i2c_stop();
    exp_ptr = p;
  endtask

  // read n bytes; when set_ptr is 0, continues from the retained pointer
  task automatic rd_txn(input bit set_ptr, input logic [7:0] ptr, input int n, input string tag);
    logic ack;
    logic [7:0] d;
    i2c_start();
    if (set_ptr) begin
      send_byte({dev7, 1'b0}, ack);
      send_byte(ptr, ack);
      exp_ptr = ptr;
      i2c_start();
    end
    send_byte({dev7, 1'b1}, ack);
    check(ack, "R7 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      check(d == em[exp_ptr], tag, d, em[exp_ptr]);
      exp_ptr = exp_ptr + 8'd1;
    end
    i2c_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] buf8 [8];
    logic ack, b;
    int w0, nb;
    logic [7:0] p;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'h00;
      em[i]  = 8'h00;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(sda_oe == 1'b0, "R1 reset sda released", sda_oe, 0);
    check(reg_we == 1'b0, "R5 reset no strobe", reg_we, 0);
    check(reg_addr == 8'h00, "R10 reset pointer", reg_addr, 0);

    // burst write then read back
    buf8[0] = 8'hA5; buf8[1] = 8'h3C; buf8[2] = 8'h0F;
    w0 = we_cnt;
    wr_txn(8'h05, 3, buf8);
    check(we_cnt - w0 == 3, "R5 strobe count", we_cnt - w0, 3);
    check(reg_addr == 8'h08, "R4 pointer after burst", reg_addr, 8'h08);
    rd_txn(1'b1, 8'h05, 3, "R7 read burst");

    // crossing into unsupported registers
    buf8[0] = 8'h11; buf8[1] = 8'h22; buf8[2] = 8'h33;
    w0 = we_cnt;
    wr_txn(8'h1E, 3, buf8);
    check(we_cnt - w0 == 2, "R6 no strobe on unsupported", we_cnt - w0, 2);
    rd_txn(1'b1, 8'h1E, 3, "R6 unsupported left unchanged");

    // pointer retained across STOP
    buf8[0] = 8'h5A;
    wr_txn(8'h10, 1, buf8);
    rd_txn(1'b0, 8'h00, 2, "R10 read from retained pointer");

    // wrap from 0xFF to 0x00
    buf8[0] = 8'hC3; buf8[1] = 8'h96;
    wr_txn(8'hFF, 2, buf8);
    check(reg_addr == 8'h01, "R4 pointer wrap", reg_addr, 8'h01);
    rd_txn(1'b1, 8'hFF, 2, "R4 wrap data");

    // host NACK ends a read; later clocks see a released line
    i2c_start();
    send_byte({dev7, 1'b0}, ack);
    send_byte(8'h05, ack);
    i2c_start();
    send_byte({dev7, 1'b1}, ack);
    recv_byte(1'b0, p);
    check(p == em[8'h05], "R8 single read byte", p, em[8'h05]);
    nb = 0;
    for (int i = 0; i < 9; i++) begin
      get_bit(b);
      if (!b) nb++;
    end
    check(nb == 0, "R8 released after host NACK", nb, 0);
    i2c_stop();
    exp_ptr = 8'h06;

    // foreign address
    w0 = we_cnt;
    i2c_start();
    send_byte({7'h50, 1'b0}, ack);
    check(!ack, "R9 foreign address NACK", ack, 0);
    send_byte(8'h02, ack);
    check(!ack, "R9 ignore later byte", ack, 0);
    send_byte(8'hEE, ack);
    i2c_stop();
    check(we_cnt == w0, "R9 no strobe", we_cnt - w0, 0);

    // address select pin only counts on general call
    addr_sel = 1'b1;
    i2c_start();
    send_byte({7'h2D, 1'b0}, ack);
    check(!ack, "R3 pin change alone ignored", ack, 0);
    i2c_stop();
    i2c_start();
    send_byte(8'h00, ack);
    check(!ack, "R3 general call not acked", ack, 0);
    i2c_stop();
    i2c_start();
    send_byte({7'h2C, 1'b0}, ack);
    check(!ack, "R3 old address dropped", ack, 0);
    i2c_stop();
    dev7 = 7'h2D;
    i2c_start();
    send_byte({dev7, 1'b0}, ack);
    check(ack, "R3 new address acked", ack, 1);
    i2c_stop();

    // aborted transfers
    i2c_start();
    for (int i = 7; i >= 4; i--) put_bit(dev7[i - 1]);
    buf8[0] = 8'h77;
    wr_txn(8'h02, 1, buf8);
    rd_txn(1'b1, 8'h02, 1, "R1 restart after partial byte");
    w0 = we_cnt;
    i2c_start();
    send_byte({dev7, 1'b0}, ack);
    send_byte(8'h03, ack);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    i2c_stop();
    check(we_cnt == w0, "R1 stop mid-byte no write", we_cnt - w0, 0);
    exp_ptr = 8'h03;
    rd_txn(1'b0, 8'h00, 1, "R1 data intact after abort");

    // random bursts
    for (int t = 0; t < 16; t++) begin
      p  = 8'($urandom_range(0, 8'h27));
      nb = $urandom_range(1, 4);
      for (int k = 0; k < 8; k++) buf8[k] = 8'($urandom);
      wr_txn(p, nb, buf8);
      rd_txn(1'b1, p, nb, "R7 random readback");
    end

    check(bad_oe == 0, "R11 sda_oe change with SCL high", bad_oe, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule